// File: doc/BRIEF.md
# Winding Current Chopper Sequencer

This block sequences the four switches of one H-bridge so that the current in a motor winding is held at a trip level. It first drives the winding in the direction given by the polarity input. A blanking window follows every turn-on, and the trip comparator is not looked at during it. When the comparator trips after blanking, the block enters an off period of fixed length and then starts driving again. During the off period the winding current decays in one of three ways. Slow decay turns on both low-side switches. Fast decay reverses the bridge. Mixed decay runs fast and then changes to slow after a programmable number of cycles.

The decay style is chosen when the trip occurs. It depends on the requested style, on the trend flag from the indexer and on whether synchronous rectification is enabled. A zero-crossing input ends reverse conduction early. Before any switch pattern turns on, every switch is held off for a dead time. A low enable turns all switches off at once and returns the sequencer to idle. Blanking, off time and dead time are counter parameters in clock cycles.

Top module: `chop_regulator`

## Requirements
- R1: While reset is asserted, and afterwards while enable is low, all four gate outputs are 0.
- R2: Drive turns on the high side of leg 0 and the low side of leg 1 when polarity is 1, and the high side of leg 1 and the low side of leg 0 when polarity is 0. Trip is ignored for BLANK_CYC cycles after drive starts. Drive targeting therefore lasts BLANK_CYC+1 cycles when trip is held high.
- R3: A trip after blanking starts an off period that lasts exactly OFF_CYC cycles. Drive then restarts with a new blanking window.
- R4: Slow decay turns on both low sides and no high side.
- R5: Fast decay with synchronous rectification applies the reverse of the drive pattern for the whole off period.
- R6: Mixed decay applies reverse for the first fast_len_i cycles of the off period and slow decay for the rest. fast_len_i = 0 gives pure slow decay.
- R7: When the trend flag i_falling_i is 0 at the trip, slow decay is used whatever the selection. decay_sel_i codes are 00 slow, 01 fast, 10 mixed and 11 slow.
- R8: With synchronous rectification disabled, all gates are off for the whole off period, whatever the selection and trend.
- R9: Any change to a non-zero pattern is preceded by DEAD_CYC cycles with all gates off. A leg never has its high and low side on together.
- R10: zero_cross_i sampled during reverse conduction turns all gates off for the rest of that off period. Drive restarts on schedule.
- R11: Enable low forces all gates off in the same cycle and sends the sequencer to idle. The next enable starts with a full blanking window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | asynchronous reset, active low |
| en_i | input | 1 | bridge enable |
| trip_i | input | 1 | current trip comparator |
| decay_sel_i | input | 2 | decay selection: 00 slow, 01 fast, 10 mixed, 11 slow |
| sync_rect_i | input | 1 | synchronous rectification enabled |
| i_falling_i | input | 1 | commanded current magnitude decreasing |
| polarity_i | input | 1 | winding current direction, 1 = leg 0 to leg 1 |
| zero_cross_i | input | 1 | winding current near zero |
| fast_len_i | input | TW | reverse duration in mixed decay, in cycles |
| hs_o | output | 2 | high-side gate enables, bit k = leg k |
| ls_o | output | 2 | low-side gate enables, bit k = leg k |

## Verification
The hardest condition to reach is the zero crossing. It has an effect only in the short window where the reverse pattern is actually on the gates, after the dead time and before the off period ends. The bench holds trip high, so the sequence runs on a fixed schedule. It tracks runs of identical gate words sampled at the negative edge and pulses zero_cross_i on the first cycle in which the reverse pattern appears. The length of the remaining runs then shows whether the reverse pattern was cut short and whether the following drive kept its schedule. Mixed decay and disabling mid-period are reached in the same way, by counting runs.

// File: rtl/chop_pkg.sv
package chop_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_BLANK, ST_ON, ST_OFF} st_e;
  typedef enum logic [1:0] {STY_SLOW, STY_FAST, STY_MIXED, STY_DIODE} sty_e;
  typedef enum logic [1:0] {PH_NONE, PH_DRIVE, PH_REV, PH_BRAKE} ph_e;

  localparam logic [1:0] SEL_FAST  = 2'b01;
  localparam logic [1:0] SEL_MIXED = 2'b10;

  // word layout {hs1, hs0, ls1, ls0}
  function automatic logic [3:0] gate_word(ph_e ph, logic pol);
    case (ph)
      PH_DRIVE: gate_word = pol ? 4'b0110 : 4'b1001;
      PH_REV:   gate_word = pol ? 4'b1001 : 4'b0110;
      PH_BRAKE: gate_word = 4'b0011;
      default:  gate_word = 4'b0000;
    endcase
  endfunction
endpackage

// File: rtl/chop_ctrl.sv
module chop_ctrl
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 125,
  parameter int OFF_CYC   = 4400,
  parameter int TW        = 13
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          trip_i,
  input  logic [1:0]    decay_sel_i,
  input  logic          sync_rect_i,
  input  logic          falling_i,
  input  logic          zero_cross_i,
  input  logic [TW-1:0] fast_len_i,
  output ph_e           phase_o
);
  localparam logic [TW-1:0] BLANK_LAST = TW'(BLANK_CYC - 1);
  localparam logic [TW-1:0] OFF_LAST   = TW'(OFF_CYC - 1);

  st_e           st_q;
  sty_e          sty_q, sty_d;
  logic [TW-1:0] cnt_q;
  logic          zc_q;
  logic          fast_act;

  always_comb begin
    if (!sync_rect_i)               sty_d = STY_DIODE;
    else if (!falling_i)            sty_d = STY_SLOW;
    else if (decay_sel_i == SEL_FAST)  sty_d = STY_FAST;
    else if (decay_sel_i == SEL_MIXED) sty_d = STY_MIXED;
    else                            sty_d = STY_SLOW;
  end

  assign fast_act = (st_q == ST_OFF) && !zc_q &&
                    ((sty_q == STY_FAST) || ((sty_q == STY_MIXED) && (cnt_q < fast_len_i)));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      sty_q <= STY_SLOW;
      cnt_q <= '0;
      zc_q  <= 1'b0;
    end else if (!en_i) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
      zc_q  <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          st_q  <= ST_BLANK;
          cnt_q <= '0;
        end
        ST_BLANK: begin
          if (cnt_q == BLANK_LAST) begin
            st_q  <= ST_ON;
            cnt_q <= '0;
          end else cnt_q <= cnt_q + 1'b1;
        end
        ST_ON: begin
          if (trip_i) begin
            st_q  <= ST_OFF;
            sty_q <= sty_d;
            cnt_q <= '0;
            zc_q  <= 1'b0;
          end
        end
        default: begin
          if (cnt_q == OFF_LAST) begin
            st_q  <= ST_BLANK;
            cnt_q <= '0;
            zc_q  <= 1'b0;
          end else begin
            cnt_q <= cnt_q + 1'b1;
            if (fast_act && zero_cross_i) zc_q <= 1'b1;
          end
        end
      endcase
    end
  end

  always_comb begin
    case (st_q)
      ST_IDLE:            phase_o = PH_NONE;
      ST_BLANK, ST_ON:    phase_o = PH_DRIVE;
      default: begin
        if (sty_q == STY_DIODE) phase_o = PH_NONE;
        else if (fast_act)      phase_o = PH_REV;
        else if (zc_q)          phase_o = PH_NONE;
        else                    phase_o = PH_BRAKE;
      end
    endcase
  end

  a_r2_blank_ignores_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_BLANK) |=> (st_q == ST_BLANK || st_q == ST_ON || st_q == ST_IDLE));
  a_r3_off_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_OFF && cnt_q == OFF_LAST) |=> st_q == ST_BLANK);
  a_r7_rising_slow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_ON && trip_i && sync_rect_i && !falling_i) |=> sty_q == STY_SLOW);
  a_r8_diode_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && st_q == ST_ON && trip_i && !sync_rect_i) |=> phase_o == PH_NONE);
  a_r11_disable_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> st_q == ST_IDLE);
endmodule

// File: rtl/chop_gate.sv
module chop_gate
  import chop_pkg::*;
#(
  parameter int DEAD_CYC = 48
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       en_i,
  input  ph_e        phase_i,
  input  logic       pol_i,
  output logic [3:0] gates_o
);
  localparam int DW = $clog2(DEAD_CYC + 1);
  localparam logic [DW-1:0] DEAD_LOAD = DW'(DEAD_CYC - 1);

  logic [3:0]    tgt, last_q, out_q;
  logic [DW-1:0] dcnt_q;

  assign tgt = gate_word(phase_i, pol_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_q <= '0;
      out_q  <= '0;
      dcnt_q <= '0;
    end else begin
      last_q <= tgt;
      if (tgt != last_q) begin
        out_q  <= '0;
        dcnt_q <= (tgt == '0) ? '0 : DEAD_LOAD;
      end else if (dcnt_q != '0) begin
        out_q  <= '0;
        dcnt_q <= dcnt_q - 1'b1;
      end else begin
        out_q <= tgt;
      end
    end
  end

  assign gates_o = en_i ? out_q : 4'b0000;

  a_r9_no_shoot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(gates_o[3] && gates_o[1]) && !(gates_o[2] && gates_o[0]));
  a_r9_dead_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (gates_o != 4'b0000 && $past(gates_o) != 4'b0000) |-> gates_o == $past(gates_o));
endmodule

// File: rtl/chop_regulator.sv
module chop_regulator
  import chop_pkg::*;
#(
  parameter int BLANK_CYC = 125,
  parameter int OFF_CYC   = 4400,
  parameter int DEAD_CYC  = 48,
  localparam int TW = $clog2(((OFF_CYC > BLANK_CYC) ? OFF_CYC : BLANK_CYC) + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          trip_i,
  input  logic [1:0]    decay_sel_i,
  input  logic          sync_rect_i,
  input  logic          i_falling_i,
  input  logic          polarity_i,
  input  logic          zero_cross_i,
  input  logic [TW-1:0] fast_len_i,
  output logic [1:0]    hs_o,
  output logic [1:0]    ls_o
);
  ph_e        phase;
  logic [3:0] gates;

  chop_ctrl #(.BLANK_CYC(BLANK_CYC), .OFF_CYC(OFF_CYC), .TW(TW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .en_i        (en_i),
    .trip_i      (trip_i),
    .decay_sel_i (decay_sel_i),
    .sync_rect_i (sync_rect_i),
    .falling_i   (i_falling_i),
    .zero_cross_i(zero_cross_i),
    .fast_len_i  (fast_len_i),
    .phase_o     (phase)
  );

  chop_gate #(.DEAD_CYC(DEAD_CYC)) u_gate (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en_i),
    .phase_i(phase),
    .pol_i  (polarity_i),
    .gates_o(gates)
  );

  assign hs_o = gates[3:2];
  assign ls_o = gates[1:0];

  a_r1_reset_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!en_i) && !en_i |-> (hs_o == 2'b00 && ls_o == 2'b00));
endmodule

// File: tb/chop_regulator_tb.sv
module chop_regulator_tb;
  localparam int B = 4;
  localparam int OFF = 12;
  localparam int D = 2;
  localparam int TW = $clog2(((OFF > B) ? OFF : B) + 1);

  localparam logic [3:0] P_POS = 4'b0110;
  localparam logic [3:0] P_NEG = 4'b1001;
  localparam logic [3:0] P_BRK = 4'b0011;
  localparam logic [3:0] P_ZER = 4'b0000;
  localparam int DRV = B + 1 - D;

  logic clk = 0, rst_n = 0, en = 0, trip = 1, sync_r = 1, fall = 1, pol = 1, zc = 0;
  logic [1:0] sel = 2'b00;
  logic [TW-1:0] flen = '0;
  logic [1:0] hs, ls;
  logic [3:0] g;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;
  assign g = {hs, ls};

  chop_regulator #(.BLANK_CYC(B), .OFF_CYC(OFF), .DEAD_CYC(D)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .trip_i(trip), .decay_sel_i(sel),
    .sync_rect_i(sync_r), .i_falling_i(fall), .polarity_i(pol), .zero_cross_i(zc),
    .fast_len_i(flen), .hs_o(hs), .ls_o(ls));

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic get_run(output logic [3:0] p, output int n);
    p = g; n = 0;
    while (g == p && n < 1000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic expect_run(input logic [3:0] p, input int n, input string tag);
    logic [3:0] ap; int an;
    get_run(ap, an);
    chk(ap == p, {tag, " pattern"}, ap, p);
    chk(an == n, {tag, " length"}, an, n);
  endtask

  task automatic start(input logic [1:0] s, input logic sr, input logic f,
                       input logic pl, input logic [TW-1:0] fl);
    @(negedge clk); en = 0;
    repeat (3) @(negedge clk);
    sel = s; sync_r = sr; fall = f; pol = pl; flen = fl;
    en = 1;
    @(negedge clk);
    while (g == P_ZER) @(negedge clk);
  endtask

  initial begin
    #2_000_000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(g == P_ZER, "R1 in reset", g, P_ZER);
    rst_n = 1;
    repeat (5) @(negedge clk);
    chk(g == P_ZER, "R1 enable low after reset", g, P_ZER);

    // slow decay, positive polarity
    start(2'b00, 1, 1, 1, 5);
    expect_run(P_POS, DRV, "R2 drive blanked");
    expect_run(P_ZER, D, "R9 dead before brake");
    expect_run(P_BRK, OFF - D, "R4 slow decay");
    expect_run(P_ZER, D, "R9 dead before drive");
    expect_run(P_POS, DRV, "R3 drive restarts");

    // fast decay, both polarities
    start(2'b01, 1, 1, 1, 0);
    expect_run(P_POS, DRV, "R2 drive pos");
    expect_run(P_ZER, D, "R9 dead before reverse");
    expect_run(P_NEG, OFF - D, "R5 reverse pos");
    expect_run(P_ZER, D, "R3 dead after off");
    start(2'b01, 1, 1, 0, 0);
    expect_run(P_NEG, DRV, "R2 drive neg");
    expect_run(P_ZER, D, "R9 dead neg");
    expect_run(P_POS, OFF - D, "R5 reverse neg");

    // mixed
    start(2'b10, 1, 1, 1, 5);
    expect_run(P_POS, DRV, "R6 drive");
    expect_run(P_ZER, D, "R6 dead 1");
    expect_run(P_NEG, 5 - D, "R6 fast part");
    expect_run(P_ZER, D, "R6 dead 2");
    expect_run(P_BRK, OFF - 5 - D, "R6 slow part");
    expect_run(P_ZER, D, "R6 dead 3");
    expect_run(P_POS, DRV, "R6 restart");
    start(2'b10, 1, 1, 1, 0);
    expect_run(P_POS, DRV, "R6 zero len drive");
    expect_run(P_ZER, D, "R6 zero len dead");
    expect_run(P_BRK, OFF - D, "R6 zero len slow");

    // rising trend forces slow
    for (int s = 0; s < 4; s++) begin
      start(2'(s), 1, 0, 1, 5);
      expect_run(P_POS, DRV, "R7 drive");
      expect_run(P_ZER, D, "R7 dead");
      expect_run(P_BRK, OFF - D, "R7 slow on rising");
    end

    // no synchronous rectification: all off
    for (int s = 0; s < 4; s++) begin
      start(2'(s), 0, s[0], 1, 5);
      expect_run(P_POS, DRV, "R8 drive");
      expect_run(P_ZER, OFF + D, "R8 diode off period");
      expect_run(P_POS, DRV, "R8 restart");
    end

    // zero crossing during reverse
    start(2'b01, 1, 1, 1, 0);
    expect_run(P_POS, DRV, "R10 drive");
    expect_run(P_ZER, D, "R10 dead");
    chk(g == P_NEG, "R10 reverse on", g, P_NEG);
    zc = 1;
    @(negedge clk); zc = 0;
    expect_run(P_NEG, 1, "R10 reverse cut");
    expect_run(P_ZER, OFF - 2 - D + D, "R10 off remainder");
    expect_run(P_POS, DRV, "R10 drive on schedule");

    // disable mid-drive and mid-off
    start(2'b01, 1, 1, 1, 0);
    @(negedge clk);
    en = 0; #1;
    chk(g == P_ZER, "R11 off same cycle in drive", g, P_ZER);
    repeat (3) @(negedge clk);
    en = 1;
    @(negedge clk);
    while (g == P_ZER) @(negedge clk);
    expect_run(P_POS, DRV, "R11 full blank after re-enable");
    expect_run(P_ZER, D, "R11 dead");
    @(negedge clk);
    en = 0; #1;
    chk(g == P_ZER, "R11 off same cycle in reverse", g, P_ZER);
    repeat (4) @(negedge clk);
    chk(g == P_ZER, "R11 stays off", g, P_ZER);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule